// File: doc/BRIEF.md
# Serial Control Register Port

This block is a serial slave that gives an external host read and write access to a bank of 16-bit control registers. The host drives an active-low select, a serial clock and a serial data line. The block returns read data on a serial output whose pad buffer is controlled by a separate enable. Every register is also presented on a flat parallel bus, so the rest of the chip can use the values directly.

A transaction is 32 bits, each field sent most significant bit first: an 8-bit opcode, an 8-bit address and a 16-bit data word. The three pins are oversampled by the local clock through synchronizers, and serial clock edges are found in the local clock domain. The serial clock may therefore run continuously or only during transfers. Deasserting select at any point returns the block to idle and discards whatever the transaction has not yet committed.

Every pin is a plain control or status wire with no valid/ready pairing. The only flow control is the host's own pacing of the serial clock. The block can never stall or refuse a bit, so it has no back-pressure.

Top module: `spi_ctrl_regs`

## Requirements
- R1: After reset, all 16 registers read as zero on `regs_flat`, and `so_en` is low.
- R2: Opcode 0x02, followed by an address and 16 data bits, writes the data to register `addr[3:0]`. The new value appears on `regs_flat[16*i +: 16]` only after the 32nd rising serial clock edge.
- R3: Opcode 0x03 returns the addressed register, MSB first. The value is captured at the 16th rising edge, and bit 15 is put on `so_data` at the falling edge that follows. Each later falling edge advances one bit, so the host samples D15..D0 on rising edges 17..32.
- R4: `so_en` is high only in the data phase of a read. It is low throughout a write, and it is low during the opcode and address phases of any transaction.
- R5: Raising `cs_n` before the 32nd rising edge of a write leaves every register unchanged. The next transaction starts again at bit 0.
- R6: Within 4 local clock cycles of `cs_n` going high, `so_en` is low.
- R7: Rising serial clock edges while `cs_n` is high have no effect. A continuous serial clock therefore gives the same results as a gated one.
- R8: An opcode other than 0x02 or 0x03 causes the rest of the transaction to be ignored. No register changes and `so_en` stays low.
- R9: Only the low 4 address bits select the register, so address 0x35 selects register 5.
- R10: Serial clock edges after the 32nd bit are ignored until `cs_n` goes high. A write is not disturbed by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, gated or continuous |
| si | input | 1 | Serial data in, sampled on rising serial clock edges |
| so_data | output | 1 | Serial data out, changes after falling serial clock edges |
| so_en | output | 1 | Output enable for the serial out pad buffer; low means high impedance |
| regs_flat | output | 256 | All registers, register i at bits [16*i +: 16] |

## Verification
Some properties are checked by assertions on every cycle:
- the output enable is never high outside a read, and it drops the cycle after a synchronized deselect;
- the bit counter restarts on deselect;
- the registers hold their value in every cycle without a write strobe;
- the serial data output moves only right after a detected falling edge;
- an ignored opcode never produces a write.

The bench scenarios show the rest, because these need whole 32-bit frames: the returned bit order, the field decoding, the address folding, and the effect of aborts, stray idle clocks and extra trailing bits on the stored values.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_idle,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [STAGES-1:0] cs_pipe, sck_pipe, si_pipe;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      si_pipe  <= '0;
      sck_prev <= 1'b0;
    end else begin
      cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n};
      sck_pipe <= {sck_pipe[STAGES-2:0], sck};
      si_pipe  <= {si_pipe[STAGES-2:0], si};
      sck_prev <= sck_pipe[STAGES-1];
    end
  end

  assign cs_idle  = cs_pipe[STAGES-1];
  assign si_s     = si_pipe[STAGES-1];
  assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_prev;
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_idle,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            si_s,
  output logic [IDXW-1:0] rd_idx,
  input  logic [DW-1:0]   rd_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            so_data,
  output logic            so_en
);
  localparam int FRAME = OPW + AW + DW;
  localparam int CNTW  = $clog2(FRAME + 1);

  phase_e          phase;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   sh;
  logic [DW-1:0]   tx;
  logic [DW-1:0]   nxt;
  logic            is_rd;

  assign nxt    = {sh[DW-2:0], si_s};
  assign rd_idx = nxt[IDXW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      is_rd   <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      so_data <= 1'b0;
      so_en   <= 1'b0;
    end else if (cs_idle) begin
      phase <= PH_CMD;
      cnt   <= '0;
      is_rd <= 1'b0;
      wr_en <= 1'b0;
      so_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (sck_rise) begin
        sh <= nxt;
        if (cnt != CNTW'(FRAME)) cnt <= cnt + 1'b1;
        case (phase)
          PH_CMD: if (cnt == CNTW'(OPW-1)) begin
            is_rd <= (nxt[7:0] == OP_READ);
            phase <= (nxt[7:0] == OP_WRITE || nxt[7:0] == OP_READ) ? PH_ADDR : PH_SKIP;
          end
          PH_ADDR: if (cnt == CNTW'(OPW+AW-1)) begin
            wr_idx <= nxt[IDXW-1:0];
            if (is_rd) begin
              tx    <= rd_data;
              phase <= PH_RDATA;
            end else begin
              phase <= PH_WDATA;
            end
          end
          PH_WDATA: if (cnt == CNTW'(FRAME-1)) begin
            wr_en   <= 1'b1;
            wr_data <= nxt;
            phase   <= PH_DONE;
          end
          PH_RDATA: if (cnt == CNTW'(FRAME-1)) phase <= PH_DONE;
          default: ;
        endcase
      end
      if (sck_fall) begin
        if (phase == PH_RDATA) begin
          so_en   <= 1'b1;
          so_data <= tx[DW-1];
          tx      <= {tx[DW-2:0], 1'b0};
        end else begin
          so_en <= 1'b0;
        end
      end
    end
  end

  // R4: output enable only ever accompanies a read frame
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    so_en |-> is_rd);
  // R6: a synchronized deselect turns the driver off on the next cycle
  p_oe_off_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !so_en);
  // R5: deselect restarts the bit count
  p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (cnt == '0));
  // R8: an ignored frame never produces a write strobe
  p_skip_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> !wr_en);
  // R3: serial output only moves right after a falling edge
  p_so_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_data) |-> $past(sck_fall));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs[g] <= '0;
      else if (wr_en && wr_idx == IDXW'(g))     regs[g] <= wr_data;
    end
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  assign rd_data = regs[rd_idx];

  // R5: without a write strobe, no register moves
  p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int OPW  = 8,
  parameter int AW   = 8,
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               si,
  output logic               so_data,
  output logic               so_en,
  output logic [NREG*DW-1:0] regs_flat
);
  localparam int IDXW = $clog2(NREG);

  logic            cs_idle, sck_rise, sck_fall, si_s;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [DW-1:0]   wr_data, rd_data;

  spi_pin_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_idle(cs_idle), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  spi_frame_ctrl #(.OPW(OPW), .AW(AW), .DW(DW), .IDXW(IDXW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .so_data(so_data), .so_en(so_en)
  );

  spi_reg_bank #(.NREG(NREG), .DW(DW), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_flat(regs_flat)
  );

  // R2: a write strobe only happens inside a selected frame
  p_write_while_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!cs_idle));
endmodule

// File: tb/tb_spi_ctrl_regs.sv
module tb_spi_ctrl_regs;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so_data, so_en;
  logic [255:0] regs_flat;

  int total = 0;
  int bad = 0;
  logic [15:0] model [16];

  always #2 clk = ~clk;

  spi_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so_data(so_data), .so_en(so_en), .regs_flat(regs_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: low half (drive si), sample outputs, high half
  task automatic bit_io(input logic b, output logic so_b, output logic oe_b);
    sck = 1'b0; si = b;
    wait_clk(H);
    so_b = so_data; oe_b = so_en;
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic deselect();
    wait_clk(H);
    sck = 1'b0;
    cs_n = 1'b1;
    wait_clk(H);
  endtask

  // full frame plus optional extra bits; returns received bits and enable mask
  task automatic frame(input logic [7:0] op, input logic [7:0] addr, input logic [15:0] d,
                       input int extra, output logic [31:0] rx, output logic [31:0] oe);
    logic [31:0] word;
    logic sb, eb;
    word = {op, addr, d};
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < 32; i++) begin
      bit_io(word[31-i], sb, eb);
      rx[31-i] = sb; oe[31-i] = eb;
    end
    for (int i = 0; i < extra; i++) bit_io(1'b1, sb, eb);
    deselect();
  endtask

  function automatic logic [15:0] reg_of(input int i);
    return regs_flat[i*16 +: 16];
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) chk(req, {16'h0, reg_of(i)}, {16'h0, model[i]});
  endtask

  task automatic t_reset();
    chk("R1 so_en", {31'h0, so_en}, 32'h0);
    chk("R1 regs", {31'h0, (regs_flat == '0)}, 32'h1);
  endtask

  task automatic t_write_read(input logic [7:0] addr, input logic [15:0] d);
    logic [31:0] rx, oe;
    frame(8'h02, addr, d, 0, rx, oe);
    model[addr[3:0]] = d;
    chk("R2 write", {16'h0, reg_of(addr[3:0])}, {16'h0, d});
    chk("R4 write oe", oe, 32'h0);
    frame(8'h03, addr, 16'h0, 0, rx, oe);
    chk("R3 read data", {16'h0, rx[15:0]}, {16'h0, d});
    chk("R4 read oe", oe, 32'h0000_FFFF);
    chk("R6 oe after cs", {31'h0, so_en}, 32'h0);
  endtask

  task automatic t_abort_write();
    logic sb, eb;
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < 24; i++)
      bit_io(i < 8 ? ((8'h02 >> (7 - i)) & 1'b1) : 1'b1, sb, eb);
    deselect();
    check_all("R5 abort write");
  endtask

  task automatic t_abort_read();
    logic [31:0] word;
    logic sb, eb;
    word = {8'h03, 8'h07, 16'h0};
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < 20; i++) bit_io(word[31-i], sb, eb);
    chk("R4 oe mid read", {31'h0, eb}, 32'h1);
    cs_n = 1'b1;
    wait_clk(4);
    chk("R6 oe drop", {31'h0, so_en}, 32'h0);
    wait_clk(H);
  endtask

  task automatic t_idle_clocks();
    logic [31:0] rx, oe;
    logic sb, eb;
    for (int i = 0; i < 10; i++) bit_io(1'b1, sb, eb);
    frame(8'h03, 8'h02, 16'h0, 0, rx, oe);
    chk("R7 read after idle clocks", {16'h0, rx[15:0]}, {16'h0, model[2]});
  endtask

  task automatic t_bad_opcode();
    logic [31:0] rx, oe;
    frame(8'h5A, 8'h01, 16'hFFFF, 0, rx, oe);
    chk("R8 oe", oe, 32'h0);
    check_all("R8 regs");
    frame(8'h07, 8'h03, 16'h1234, 0, rx, oe);
    chk("R8 oe op07", oe, 32'h0);
    check_all("R8 regs op07");
  endtask

  task automatic t_extra_bits();
    logic [31:0] rx, oe;
    frame(8'h02, 8'h0C, 16'h6A5C, 9, rx, oe);
    model[12] = 16'h6A5C;
    chk("R10 extra bits", {16'h0, reg_of(12)}, {16'h0, 16'h6A5C});
    check_all("R10 others");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_read(8'h00, 16'hA55A);
    t_write_read(8'h02, 16'h8001);
    t_write_read(8'h0F, 16'hFFFF);
    t_write_read(8'h35, 16'h1357);   // R9: folds onto register 5
    chk("R9 reg5", {16'h0, reg_of(5)}, {16'h0, 16'h1357});
    t_abort_write();
    t_abort_read();
    t_idle_clocks();
    t_bad_opcode();
    t_extra_bits();
    t_write_read(8'h07, 16'h0F0F);
    check_all("R2 final bank");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule